// File: doc/BRIEF.md
# Multicart Outer Bank Register File

This block sits beside the bank-switching logic of a multi-game cartridge and turns the inner bank numbers that logic produces into the bank numbers actually presented to the program and pattern memories. Four 8-bit outer registers select which game's slice of memory is visible. They confine program banks through a clear mask and an OR offset, and pattern banks through a size-coded AND mask, an OR offset and a 256-bank page step.

All four registers are loaded through a single CPU address window covering $6000 to $7FFF. Each accepted write lands in the register named by a 2-bit write pointer, and the pointer then steps on, wrapping after register 3. A menu program therefore writes the four values back to back. Setting bit 6 of register 3 freezes the whole file, and the pointer with it, until reset, so the selected game cannot move its own window. The final bank outputs are combinational in the registers and the inner-bank inputs, so every slot reflects the current configuration at all times.

Top module: `outer_bank_regfile`

## Requirements
- R1: A CPU write (cpu_we high) whose address has bits [15:13] equal to 3'b011 ($6000 to $7FFF), while unlocked, stores cpu_data into outer register number ptr at the clock edge; ptr then becomes (ptr + 1) mod 4, so the four registers fill in the order 0, 1, 2, 3, 0, ...
- R2: A CPU write to any address outside $6000 to $7FFF changes neither the registers nor the pointer.
- R3: While bit 6 of outer register 3 is 1, window writes are ignored: no register and not the pointer change.
- R4: Each of the 4 final PRG banks equals ((inner AND NOT {2'b00, reg3[5:0]}) AND 8'h3F) OR reg1, 8 bits wide.
- R5: The CHR AND-mask is decoded from reg2[3:0]: codes 0 to 7 give 8'h00; codes 8 to 15 give 8'h01, 8'h03, 8'h07, 8'h0F, 8'h1F, 8'h3F, 8'h7F, 8'hFF, that is (2 to the power (code minus 7)) minus 1.
- R6: Each of the 8 final CHR banks, 9 bits wide, equals ((inner AND mask) OR reg0) plus 256 times reg2[4].
- R7: An active-low reset clears all four registers and the pointer, so afterwards each PRG bank equals inner AND 8'h3F and each CHR bank is 0.
- R8: The final banks are combinational: a change of an inner-bank input, or a register update, is visible on the outputs without any further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| prg_inner | input | 4x8 | Inner 8K PRG bank number per slot |
| chr_inner | input | 8x8 | Inner 1K CHR bank number per slot |
| prg_final | output | 4x8 | Final 8K PRG bank number per slot |
| chr_final | output | 8x9 | Final 1K CHR bank number per slot |

## Verification
On every cycle the assertions check that an accepted window write stores its data in the pointed register and advances the pointer by one with wrap, that writes outside the window or while locked leave the file untouched, that PRG bits cleared by the reg3 mask and the top two PRG bits carry reg1, that the CHR page bit follows reg2 bit 4, and that a zero-mask code passes reg0 straight through. Only the bench's scenarios show the complete arithmetic over all sixteen mask codes with many inner patterns, the register fill order after interleaved foreign writes, the reset values and the lock taking effect from the write that sets it.

// File: rtl/obr_pkg.sv
package obr_pkg;
    parameter int DATA_W     = 8;
    parameter int NUM_OUTER  = 4;
    parameter int PRG_SLOTS  = 4;
    parameter int CHR_SLOTS  = 8;
    parameter int PRG_KEEP_W = 6;
    parameter int SIZE_W     = 4;
    parameter int LOCK_BIT   = 6;
    parameter int PAGE_BIT   = 4;
    localparam int PTR_W     = $clog2(NUM_OUTER);
    localparam int CHR_OUT_W = DATA_W + 1;
    localparam int REG_CHR_OFS  = 0;
    localparam int REG_PRG_OFS  = 1;
    localparam int REG_CHR_CTL  = 2;
    localparam int REG_PRG_CTL  = 3;
endpackage

// File: rtl/obr_window_regs.sv
module obr_window_regs
    import obr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NUM_OUTER,
    parameter int PW = PTR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            cpu_addr,
    input  logic [DW-1:0]          cpu_data,
    input  logic                   cpu_we,
    output logic [NR-1:0][DW-1:0]  regs,
    output logic [PW-1:0]          ptr
);
    typedef struct packed {
        logic [NR-1:0][DW-1:0] regs;
        logic [PW-1:0]         ptr;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       in_window;
    logic       locked;

    always_comb begin
        in_window = (cpu_addr[15:13] == 3'b011);
        locked    = st_q.regs[REG_PRG_CTL][LOCK_BIT];
        st_d      = st_q;
        if (cpu_we && in_window && !locked) begin
            st_d.regs[st_q.ptr] = cpu_data;
            st_d.ptr            = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.regs;
    assign ptr  = st_q.ptr;
endmodule

// File: rtl/obr_prg_map.sv
module obr_prg_map
    import obr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NS = PRG_SLOTS,
    parameter int KW = PRG_KEEP_W
) (
    input  logic [NS-1:0][DW-1:0] inner,
    input  logic [DW-1:0]         clr_ctl,
    input  logic [DW-1:0]         or_ofs,
    output logic [NS-1:0][DW-1:0] final_bank
);
    logic [DW-1:0] keep;

    always_comb begin
        keep = '0;
        keep[KW-1:0] = ~clr_ctl[KW-1:0];
    end

    for (genvar s = 0; s < NS; s++) begin : g_slot
        always_comb begin
            final_bank[s] = (inner[s] & keep) | or_ofs;
        end
    end
endmodule

// File: rtl/obr_chr_map.sv
module obr_chr_map
    import obr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NS = CHR_SLOTS,
    parameter int CW = SIZE_W,
    parameter int PB = PAGE_BIT
) (
    input  logic [NS-1:0][DW-1:0] inner,
    input  logic [DW-1:0]         size_ctl,
    input  logic [DW-1:0]         or_ofs,
    output logic [NS-1:0][DW:0]   final_bank
);
    localparam int SHW = CW;

    logic [DW:0]   wide_mask;
    logic [DW-1:0] and_mask;
    logic [SHW-1:0] shamt;
    logic [DW:0]   page_add;

    always_comb begin
        shamt     = {1'b0, size_ctl[CW-2:0]} + {{(SHW-1){1'b0}}, 1'b1};
        wide_mask = ({{DW{1'b0}}, 1'b1} << shamt) - {{DW{1'b0}}, 1'b1};
        and_mask  = size_ctl[CW-1] ? wide_mask[DW-1:0] : '0;
        page_add  = '0;
        page_add[DW] = size_ctl[PB];
    end

    for (genvar s = 0; s < NS; s++) begin : g_slot
        always_comb begin
            final_bank[s] = {1'b0, (inner[s] & and_mask) | or_ofs} + page_add;
        end
    end
endmodule

// File: rtl/outer_bank_regfile.sv
module outer_bank_regfile
    import obr_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int NPS = PRG_SLOTS,
    parameter int NCS = CHR_SLOTS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            cpu_addr,
    input  logic [DW-1:0]          cpu_data,
    input  logic                   cpu_we,
    input  logic [NPS-1:0][DW-1:0] prg_inner,
    input  logic [NCS-1:0][DW-1:0] chr_inner,
    output logic [NPS-1:0][DW-1:0] prg_final,
    output logic [NCS-1:0][DW:0]   chr_final
);
    logic [NUM_OUTER-1:0][DW-1:0] outer_q;
    logic [PTR_W-1:0]             wptr_q;

    obr_window_regs #(.DW(DW), .NR(NUM_OUTER), .PW(PTR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_we   (cpu_we),
        .regs     (outer_q),
        .ptr      (wptr_q)
    );

    obr_prg_map #(.DW(DW), .NS(NPS), .KW(PRG_KEEP_W)) u_prg (
        .inner      (prg_inner),
        .clr_ctl    (outer_q[REG_PRG_CTL]),
        .or_ofs     (outer_q[REG_PRG_OFS]),
        .final_bank (prg_final)
    );

    obr_chr_map #(.DW(DW), .NS(NCS), .CW(SIZE_W), .PB(PAGE_BIT)) u_chr (
        .inner      (chr_inner),
        .size_ctl   (outer_q[REG_CHR_CTL]),
        .or_ofs     (outer_q[REG_CHR_OFS]),
        .final_bank (chr_final)
    );
endmodule

// File: rtl/obr_checker.sv
module obr_checker
    import obr_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int NPS = PRG_SLOTS,
    parameter int NCS = CHR_SLOTS
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [15:0]                  cpu_addr,
    input logic [DW-1:0]                cpu_data,
    input logic                         cpu_we,
    input logic [NUM_OUTER-1:0][DW-1:0] outer_q,
    input logic [PTR_W-1:0]             wptr_q,
    input logic [NPS-1:0][DW-1:0]       prg_final,
    input logic [NCS-1:0][DW:0]         chr_final
);
    logic hit_win;
    logic is_locked;
    assign hit_win   = cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF;
    assign is_locked = outer_q[3][6];

    a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && hit_win && !is_locked) |=> (wptr_q == $past(wptr_q) + 2'd1));

    a_r1_data_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && hit_win && !is_locked) |=> (outer_q[$past(wptr_q)] == $past(cpu_data)));

    a_r2_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !hit_win) |=> ($stable(outer_q) && $stable(wptr_q)));

    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && is_locked) |=> ($stable(outer_q) && $stable(wptr_q)));

    for (genvar s = 0; s < NPS; s++) begin : g_prg
        a_r4_prg_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
            prg_final[s][7:6] == outer_q[1][7:6]);
        a_r4_prg_cleared_bits: assert property (@(posedge clk) disable iff (!rst_n)
            ((prg_final[s] ^ outer_q[1]) & {2'b00, outer_q[3][5:0]}) == 8'h00);
    end

    for (genvar s = 0; s < NCS; s++) begin : g_chr
        a_r6_chr_page: assert property (@(posedge clk) disable iff (!rst_n)
            chr_final[s][8] == outer_q[2][4]);
        a_r5_chr_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
            !outer_q[2][3] |-> (chr_final[s][7:0] == outer_q[0]));
    end
endmodule

bind outer_bank_regfile obr_checker #(.DW(DW), .NPS(NPS), .NCS(NCS)) u_obr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .cpu_we    (cpu_we),
    .outer_q   (outer_q),
    .wptr_q    (wptr_q),
    .prg_final (prg_final),
    .chr_final (chr_final)
);

// File: tb/tb_outer_bank_regfile.sv
module tb_outer_bank_regfile;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_data = '0;
    logic              cpu_we = 1'b0;
    logic [3:0][7:0]   prg_inner = '0;
    logic [7:0][7:0]   chr_inner = '0;
    logic [3:0][7:0]   prg_final;
    logic [7:0][8:0]   chr_final;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_reg [4];
    int m_ptr;

    outer_bank_regfile dut (
        .clk, .rst_n, .cpu_addr, .cpu_data, .cpu_we,
        .prg_inner, .chr_inner, .prg_final, .chr_final
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int mask_of(int code);
        if (code < 8) return 0;
        return (1 << (code - 7)) - 1;
    endfunction

    function automatic int exp_prg(int inner);
        return ((inner & ~(m_reg[3] & 63)) & 63) | m_reg[1];
    endfunction

    function automatic int exp_chr(int inner);
        return ((inner & mask_of(m_reg[2] & 15)) | m_reg[0]) + (((m_reg[2] >> 4) & 1) * 256);
    endfunction

    task automatic win_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a >= 16'h6000 && a <= 16'h7FFF && ((m_reg[3] >> 6) & 1) == 0) begin
            m_reg[m_ptr] = d;
            m_ptr = (m_ptr + 1) % 4;
        end
    endtask

    task automatic set_inner(input int k);
        for (int i = 0; i < 4; i++) prg_inner[i] = 8'((k * 37 + i * 11 + 5) & 255);
        for (int i = 0; i < 8; i++) chr_inner[i] = 8'((k * 53 + i * 29 + 3) & 255);
    endtask

    task automatic check_all(input string tag);
        #1;
        for (int i = 0; i < 4; i++) begin
            n_vec++;
            if (int'(prg_final[i]) != exp_prg(int'(prg_inner[i]))) begin
                n_bad++;
                $display("FAIL %s R4 prg slot %0d: got %0d expected %0d", tag, i,
                         prg_final[i], exp_prg(int'(prg_inner[i])));
            end
        end
        for (int i = 0; i < 8; i++) begin
            n_vec++;
            if (int'(chr_final[i]) != exp_chr(int'(chr_inner[i]))) begin
                n_bad++;
                $display("FAIL %s R5/R6 chr slot %0d: got %0d expected %0d", tag, i,
                         chr_final[i], exp_chr(int'(chr_inner[i])));
            end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = 0;
        m_ptr = 0;
        set_inner(1);
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state seen through outputs, several inner patterns
        for (int k = 0; k < 4; k++) begin
            set_inner(k + 2);
            check_all("R7 reset");
        end

        // R1 R4 R5 R6 R8: sweep configurations, all mask codes, both page bits
        for (int cfg = 0; cfg < 32; cfg++) begin
            win_write(16'h6000 + 16'(cfg * 97), 8'((cfg * 23) & 255));
            win_write(16'h7FFF - 16'(cfg * 13), 8'((cfg * 9 + 1) & 255));
            win_write(16'h6800, 8'(((cfg >> 4) & 1) * 16 + (cfg & 15) + (cfg & 1) * 128));
            win_write(16'h7000, 8'(((cfg * 13) & 63) | ((cfg & 2) << 6)));
            check_all("R1 cfg");
            for (int k = 0; k < 8; k++) begin
                set_inner(cfg * 8 + k);
                check_all("R8 inner");
            end
        end

        // R2: foreign writes between window writes move nothing
        win_write(16'h6123, 8'h05);
        win_write(16'h8000, 8'hAA);
        win_write(16'h5FFF, 8'hBB);
        win_write(16'hE001, 8'hCC);
        win_write(16'hFFFF, 8'hDD);
        check_all("R2 after foreign");
        win_write(16'h7FFF, 8'h82);
        win_write(16'h8001, 8'h4F);
        win_write(16'h6000, 8'h1A);
        win_write(16'hC000, 8'h40);
        win_write(16'h6000, 8'h07);
        for (int k = 0; k < 4; k++) begin
            set_inner(300 + k);
            check_all("R2 fill order");
        end

        // R3: lock from the write that sets bit 6 of register 3
        win_write(16'h6000, 8'h11);
        win_write(16'h6000, 8'h80);
        win_write(16'h6000, 8'h0C);
        win_write(16'h6000, 8'h45);
        check_all("R3 lock set");
        for (int k = 0; k < 6; k++) begin
            win_write(16'h6000 + 16'(k * 1000), 8'hFF - 8'(k));
            set_inner(400 + k);
            check_all("R3 locked");
        end

        // R7: reset again clears a locked file
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) m_reg[i] = 0;
        m_ptr = 0;
        #(CLK_PERIOD * 2);
        @(negedge clk);
        rst_n = 1'b1;
        set_inner(500);
        check_all("R7 second reset");
        win_write(16'h6000, 8'h33);
        check_all("R7 unlocked after reset");

        finished = 1'b1;
        summary();
    end
endmodule